// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for indirect data accesses. It holds a bank of address pointers, a bank of signed step (modify) registers, and per-pointer length and base registers. Each access request names one pointer and one step register. On the next cycle the block presents that pointer's current value as the address. At the same clock edge it writes the stepped value back into the pointer, so a new access can start on every cycle with no stall.

A pointer with a length of zero steps linearly and rolls over at the top of the address space. A pointer with a nonzero length walks a circular buffer that starts at its base. When a step carries the pointer past either end of the buffer, the block folds it back inside by adding or subtracting the length. Software loads all registers through a single write port. Writing a pointer also sets that pointer's buffer base to the same value. The base can also be written on its own.

Top module: `circ_addr_gen`

## Requirements
- R1: While `rst` is high, on each clock edge `addr_valid` becomes 0 and `addr_out` becomes 0. All pointer, step, length and base registers also become 0, so an access made just after reset presents address 0.
- R2: `addr_valid` is high in exactly the cycles that follow a cycle with `acc_en` high. In the cycles after an idle cycle, `addr_out` keeps its previous value.
- R3: The address presented for an access is the value the selected pointer held before that access updated it (post-modify).
- R4: The write port loads the register named by `wr_sel`, using the encoding 0 = pointer, 1 = step, 2 = length, 3 = base, at index `wr_idx`. The value is visible from the next cycle. A pointer write (`wr_sel` = 0) also loads the same value into that pointer's base.
- R5: With length 0, the updated pointer is (P + M) mod 2^AW, where P is the pointer and M is the step read as signed two's complement. For example, 0x3FFF + 1 gives 0x0000, and 0x0000 + 0x3FFF (that is, -1) gives 0x3FFF.
- R6: With length L ≠ 0 and base B, the block first forms the raw sum S = P + M. If S ≥ B + L, the new pointer is S − L. Otherwise, if S < B, the new pointer is S + L. Otherwise it is S. The result is taken mod 2^AW. When P lies in [B, B+L−1] and |M| ≤ L, the new pointer lies in [B, B+L−1]. A step equal to L leaves the pointer unchanged.
- R7: Any step register can be used with any pointer. An access changes only the pointer it selects.
- R8: Accesses may be issued on consecutive cycles. A second access to the same pointer presents the already updated value.
- R9: If a pointer write and an access target the same pointer in one cycle, the access still presents the old value. The written value then replaces the stepped value.
- R10: An access uses the step, length and base values held before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register class: 0 pointer, 1 step, 2 length, 3 base |
| wr_idx | input | IW (2) | Register index within the class |
| wr_data | input | AW (14) | Write value |
| acc_en | input | 1 | Access request |
| acc_ptr | input | IW (2) | Pointer used by the access |
| acc_mod | input | IW (2) | Step register used by the access |
| addr_valid | output | 1 | Registered flag: an address is presented |
| addr_out | output | AW (14) | Registered address (pre-update pointer value) |

## Verification
The address and valid flag appear one clock edge after the request, and the pointer update lands on that same edge. The follow-on effect of any write or step can therefore be observed through an access issued in the next cycle, and that access's address appears one edge later. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, so each comparison lines up with the request exactly one edge earlier. A bench reference model is advanced in the same order as the block. The access reads the old register values, the stepped pointer is written back, and a pointer write then overrides it. This ordering also covers same-cycle collisions.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_STEP = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_BASE = 2'd3
  } cag_sel_e;
endpackage

// File: rtl/cag_regbank.sv
module cag_regbank #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [AW-1:0]             wdata,
  output logic [NREG-1:0][AW-1:0]   q_all
);
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_all[gi] <= '0;
        end else if (we && (widx == IW'(gi))) begin
          q_all[gi] <= wdata;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cag_ptr_bank.sv
module cag_ptr_bank #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [AW-1:0]             wdata,
  input  logic                      upd_en,
  input  logic [IW-1:0]             upd_idx,
  input  logic [AW-1:0]             upd_val,
  output logic [NREG-1:0][AW-1:0]   q_all
);
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_ptr
      always_ff @(posedge clk) begin
        if (rst) begin
          q_all[gi] <= '0;
        end else if (we && (widx == IW'(gi))) begin
          q_all[gi] <= wdata;          // software write takes precedence
        end else if (upd_en && (upd_idx == IW'(gi))) begin
          q_all[gi] <= upd_val;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cag_wrap.sv
module cag_wrap #(
  parameter int AW  = 14,
  localparam int XW = AW + 2
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  logic signed [XW-1:0] cur_x, step_x, base_x, end_x, len_x, raw, fold;

  always_comb begin
    cur_x  = $signed({2'b00, cur});
    step_x = $signed({{2{step[AW-1]}}, step});
    base_x = $signed({2'b00, base});
    len_x  = $signed({2'b00, len});
    end_x  = base_x + len_x;
    raw    = cur_x + step_x;
    if (len == '0) begin
      fold = raw;
    end else if (raw >= end_x) begin
      fold = raw - len_x;
    end else if (raw < base_x) begin
      fold = raw + len_x;
    end else begin
      fold = raw;
    end
    nxt = fold[AW-1:0];
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_en,
  input  logic [IW-1:0] acc_ptr,
  input  logic [IW-1:0] acc_mod,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);
  import cag_pkg::*;

  cag_sel_e sel;
  logic we_ptr, we_step, we_len, we_base;
  logic [NREG-1:0][AW-1:0] ptr_q, mod_q, len_q, base_q;
  logic [AW-1:0] cur_ptr, next_ptr;

  always_comb begin
    sel     = cag_sel_e'(wr_sel);
    we_ptr  = wr_en && (sel == SEL_PTR);
    we_step = wr_en && (sel == SEL_STEP);
    we_len  = wr_en && (sel == SEL_LEN);
    we_base = wr_en && ((sel == SEL_BASE) || (sel == SEL_PTR));
  end

  cag_ptr_bank #(.AW(AW), .NREG(NREG)) u_ptr (
    .clk(clk), .rst(rst), .we(we_ptr), .widx(wr_idx), .wdata(wr_data),
    .upd_en(acc_en), .upd_idx(acc_ptr), .upd_val(next_ptr), .q_all(ptr_q)
  );
  cag_regbank #(.AW(AW), .NREG(NREG)) u_step (
    .clk(clk), .rst(rst), .we(we_step), .widx(wr_idx), .wdata(wr_data), .q_all(mod_q)
  );
  cag_regbank #(.AW(AW), .NREG(NREG)) u_len (
    .clk(clk), .rst(rst), .we(we_len), .widx(wr_idx), .wdata(wr_data), .q_all(len_q)
  );
  cag_regbank #(.AW(AW), .NREG(NREG)) u_base (
    .clk(clk), .rst(rst), .we(we_base), .widx(wr_idx), .wdata(wr_data), .q_all(base_q)
  );

  assign cur_ptr = ptr_q[acc_ptr];

  cag_wrap #(.AW(AW)) u_wrap (
    .cur(cur_ptr), .step(mod_q[acc_mod]), .base(base_q[acc_ptr]),
    .len(len_q[acc_ptr]), .nxt(next_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= acc_en;
      if (acc_en) addr_out <= cur_ptr;
    end
  end
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int AW   = 14,
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [1:0]              wr_sel,
  input logic [IW-1:0]           wr_idx,
  input logic [AW-1:0]           wr_data,
  input logic                    acc_en,
  input logic [IW-1:0]           acc_ptr,
  input logic [IW-1:0]           acc_mod,
  input logic                    addr_valid,
  input logic [AW-1:0]           addr_out,
  input logic [NREG-1:0][AW-1:0] ptr_q,
  input logic [NREG-1:0][AW-1:0] mod_q,
  input logic [NREG-1:0][AW-1:0] len_q,
  input logic [NREG-1:0][AW-1:0] base_q
);
  function automatic logic in_ring(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                   input logic [AW-1:0] l);
    return ({2'b00, p} >= {2'b00, b}) && ({2'b00, p} < ({2'b00, b} + {2'b00, l}));
  endfunction

  function automatic logic [AW-1:0] mag(input logic [AW-1:0] m);
    return m[AW-1] ? (~m + 1'b1) : m;
  endfunction

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!addr_valid && addr_out == '0)); // R1

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (!addr_valid && $stable(addr_out))); // R2

  AST_PRE_MODIFY_ADDR: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_out == $past(ptr_q[acc_ptr])); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_en && len_q[acc_ptr] == '0 && !(wr_en && wr_sel == 2'd0 && wr_idx == acc_ptr))
    |=> ptr_q[$past(acc_ptr)] == $past(ptr_q[acc_ptr] + mod_q[acc_mod])); // R5

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_chk
      AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && wr_idx == IW'(gi))
        |=> (ptr_q[gi] == $past(wr_data) && base_q[gi] == $past(wr_data))); // R9

      AST_STAY_IN_RING: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_ptr == IW'(gi) && len_q[gi] != '0 &&
         in_ring(ptr_q[gi], base_q[gi], len_q[gi]) &&
         (mag(mod_q[acc_mod]) <= len_q[gi]) &&
         !(wr_en && wr_idx == IW'(gi) && wr_sel != 2'd1))
        |=> in_ring(ptr_q[gi], base_q[gi], len_q[gi])); // R6

      AST_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_ptr != IW'(gi) && !(wr_en && wr_sel == 2'd0 && wr_idx == IW'(gi)))
        |=> $stable(ptr_q[gi])); // R7
    end
  endgenerate
endmodule

bind circ_addr_gen cag_checker #(.AW(AW), .NREG(NREG)) u_cag_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
  .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
  .addr_valid(addr_valid), .addr_out(addr_out), .ptr_q(ptr_q), .mod_q(mod_q),
  .len_q(len_q), .base_q(base_q)
);

// File: tb/circ_addr_gen_bench.sv
module circ_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int NREG = 4;
  localparam int IW = 2;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [1:0] wr_sel;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_data;
  logic acc_en;
  logic [IW-1:0] acc_ptr, acc_mod;
  logic addr_valid;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_ptr[NREG], m_mod[NREG], m_len[NREG], m_base[NREG];
  int e_valid, e_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_addr_gen #(.AW(AW), .NREG(NREG)) u_circ_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  function automatic int step_next(int p, int m, int b, int l);
    int ms = (m >= (1 << (AW-1))) ? m - (1 << AW) : m;
    int s = p + ms;
    if (l != 0) begin
      if (s >= b + l) s = s - l;
      else if (s < b) s = s + l;
    end
    return s & AMASK;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, advance the model, compare at the next falling edge.
  task automatic cyc(bit we, int sel, int idx, int data, bit ae, int ap, int am, string req);
    wr_en = we; wr_sel = sel[1:0]; wr_idx = idx[IW-1:0]; wr_data = data[AW-1:0];
    acc_en = ae; acc_ptr = ap[IW-1:0]; acc_mod = am[IW-1:0];
    e_valid = ae;
    if (ae) begin
      e_addr = m_ptr[ap];
      m_ptr[ap] = step_next(m_ptr[ap], m_mod[am], m_base[ap], m_len[ap]);
    end
    if (we) begin
      case (sel)
        0: begin m_ptr[idx] = data & AMASK; m_base[idx] = data & AMASK; end
        1: m_mod[idx] = data & AMASK;
        2: m_len[idx] = data & AMASK;
        default: m_base[idx] = data & AMASK;
      endcase
    end
    @(negedge clk);
    chk({req, " valid"}, int'(addr_valid), e_valid);
    chk({req, " addr"}, int'(addr_out), e_addr);
  endtask

  task automatic wr(int sel, int idx, int data, string req);
    cyc(1, sel, idx, data, 0, 0, 0, req);
  endtask

  task automatic acc(int ap, int am, string req);
    cyc(0, 0, 0, 0, 1, ap, am, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; wr_en = 0; wr_sel = 0; wr_idx = 0; wr_data = 0;
    acc_en = 0; acc_ptr = 0; acc_mod = 0;
    for (int i = 0; i < NREG; i++) begin m_ptr[i]=0; m_mod[i]=0; m_len[i]=0; m_base[i]=0; end
    e_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(addr_valid), 0);
    chk("R1 reset addr", int'(addr_out), 0);
    rst = 0;
    cyc(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    for (int i = 0; i < NREG; i++) acc(i, i, "R1 pointer zero after reset");

    // linear stepping, post-modify, back-to-back
    wr(0, 0, 100, "R4"); wr(1, 0, 3, "R4");
    acc(0, 0, "R3 first"); acc(0, 0, "R8 b2b"); acc(0, 0, "R8 b2b");
    cyc(0, 0, 0, 0, 0, 0, 0, "R2 hold");

    // rollover both directions
    wr(0, 1, 16'h3FFE, "R4"); wr(1, 1, 1, "R4");
    acc(1, 1, "R5 up"); acc(1, 1, "R5 up"); acc(1, 1, "R5 wrap to 0");
    wr(0, 2, 0, "R4"); wr(1, 2, 16'h3FFF, "R4");
    acc(2, 2, "R5 down"); acc(2, 2, "R5 wrap to top"); acc(2, 2, "R5 down");

    // circular buffer base 200 length 5
    wr(0, 3, 200, "R4"); wr(2, 3, 5, "R4"); wr(1, 3, 2, "R4");
    for (int k = 0; k < 6; k++) acc(3, 3, "R6 forward ring");
    for (int k = 0; k < 6; k++) acc(3, 2, "R6 backward ring");
    wr(1, 1, 5, "R4");
    acc(3, 1, "R6 step equals length"); acc(3, 1, "R6 step equals length");
    wr(1, 1, 1, "R4");
    // separate base write moves the ring
    wr(3, 3, 198, "R4 base write");
    for (int k = 0; k < 5; k++) acc(3, 3, "R4 R6 moved ring");

    // collisions
    cyc(1, 0, 0, 500, 1, 0, 0, "R9 write vs access");
    acc(0, 0, "R9 write won");
    cyc(1, 1, 0, 7, 1, 0, 0, "R10 step write same cycle");
    acc(0, 0, "R10 new step next");
    cyc(1, 2, 3, 3, 1, 3, 3, "R10 length write same cycle");
    acc(3, 3, "R10 new length next");
    acc(1, 0, "R7 any step any pointer");

    // constrained random
    for (int k = 0; k < 2000; k++) begin
      bit we = ($urandom % 10) < 3;
      int sel = $urandom % 3;
      int idx = $urandom % NREG;
      int data;
      bit ae = ($urandom % 10) < 8;
      if (sel == 0) data = $urandom & AMASK;
      else if (sel == 1) data = (($urandom % 17) - 8) & AMASK;
      else data = $urandom % 17;
      cyc(we, sel, idx, data, ae, $urandom % NREG, $urandom % NREG, "R7 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule